// File: doc/BRIEF.md
# Interrupt Controller Base and Mode Register

This block holds the base-address and mode word of a per-core local interrupt controller. Software writes a 64-bit word through a write strobe. The block checks the word against the reserved-bit rules, against the physical address width and against the allowed mode transitions. A legal write replaces the stored word and raises a one-cycle relocation pulse, which the controller and any address-translation logic use to pick up the new base. An illegal write leaves the register unchanged and raises a one-cycle fault pulse instead, which the core turns into a protection fault. A read strobe copies the stored word to a registered read port.

The mode sits in word bits 11:10. Bit 11 is the global enable and bit 10 selects the register-addressed extended mode. That gives four codes: 00 off, 01 illegal, 10 normal enabled and 11 extended. Once the global enable bit has been cleared, every later write is accepted without a fault but changes nothing, so only a reset brings the controller back. The parameter `EXT_MODE` says whether extended mode exists. Bit 8 flags the bootstrap core and is loaded from `boot_i` at reset.

Top module: `lic_base_reg`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the stored word is base 0xFEE00000 with mode 10 and bit 8 equal to `boot_i`; `fault_o`, `reloc_o` and `rd_data_o` are 0.
- R2: A legal write made while bit 11 of the stored word is 1 stores the written word. From the next cycle `base_addr_o` shows bits PA_W-1:12 of that word with zeros in bits 11:0, `mode_o` shows bits 11:10 of it, and `reloc_o` is 1 for exactly that one cycle.
- R3: A write that has any of bits 7:0 or bit 9 set faults: `fault_o` is 1 in the next cycle and the stored word is unchanged.
- R4: A write that has any bit at or above bit PA_W set faults and leaves the stored word unchanged.
- R5: A write whose bits 11:10 are 01 and differ from the stored mode faults.
- R6: From stored mode 11, the only other mode a write may set is 00; a write that sets 10 faults.
- R7: A write whose bits 11:10 equal the stored mode skips the transition rules; for example, 11 to 11 with a new base commits.
- R8: While bit 11 of the stored word is 0, a write of any value raises neither `fault_o` nor `reloc_o` and changes nothing.
- R9: With `EXT_MODE` = 0, bit 10 counts as reserved, so a write with bit 10 set faults.
- R10: `rd_en_i` high loads `rd_data_o` in the next cycle with the word stored before that edge: the base in bits PA_W-1:12, the mode in bits 11:10, the bootstrap flag in bit 8 and zeros elsewhere. Otherwise `rd_data_o` holds its value.
- R11: `fault_o` and `reloc_o` are never high together, and each lasts only one cycle for each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_i | input | 1 | Bootstrap-core flag, loaded into bit 8 at reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Word to write |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Registered copy of the stored word |
| base_addr_o | output | PA_W | Current base address, low 12 bits zero |
| mode_o | output | 2 | Current mode (enable, extended) |
| fault_o | output | 1 | One-cycle pulse after a rejected write |
| reloc_o | output | 1 | One-cycle pulse after a committed write |

## Verification
The assertions take it that at most one write is presented each cycle and that `wr_data_i` is held stable while the strobe is high. They also take the stored mode before an edge as the reference for the transition rules. The stimulus drives each strobe for a single cycle, shortly after the rising edge. It follows every write or read with at least one idle cycle and asserts reset again once the enable bit has dropped. Two instances, one with extended mode and one without, get the same stimulus, so each instance sees the transition corners from its own mode.

// File: rtl/lic_pkg.sv
package lic_pkg;

  // Field positions inside the register word; the mode decode depends on them.
  localparam int BOOT_POS = 8;
  localparam int MODE_LSB = 10;
  localparam int ENA_POS  = 11;
  localparam int BASE_LSB = 12;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_BAD    = 2'b01,
    MODE_LEGACY = 2'b10,
    MODE_EXT    = 2'b11
  } lic_mode_e;

  typedef struct packed {
    logic rsvd;
    logic wide;
    logic trans;
  } lic_viol_t;

endpackage

// File: rtl/lic_field_check.sv
module lic_field_check
  import lic_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int PA_W     = 36,
  parameter bit EXT_MODE = 1'b1
) (
  input  logic [DATA_W-1:0]      word_i,
  output logic [PA_W-1:BASE_LSB] base_o,
  output lic_mode_e              mode_o,
  output logic                   boot_o,
  output logic                   rsvd_o,
  output logic                   wide_o
);

  // Bits 7:0 and 9 are always reserved; bit 10 joins them without extended mode.
  localparam logic [BASE_LSB-1:0] RSVD_MASK = EXT_MODE ? 12'h2FF : 12'h6FF;

  assign base_o = word_i[PA_W-1:BASE_LSB];
  assign mode_o = lic_mode_e'(word_i[ENA_POS:MODE_LSB]);
  assign boot_o = word_i[BOOT_POS];
  assign rsvd_o = |(word_i[BASE_LSB-1:0] & RSVD_MASK);

  generate
    if (PA_W < DATA_W) begin : g_wide
      assign wide_o = |word_i[DATA_W-1:PA_W];
    end else begin : g_full
      assign wide_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/lic_mode_check.sv
module lic_mode_check
  import lic_pkg::*;
(
  input  lic_mode_e cur_i,
  input  lic_mode_e new_i,
  output logic      bad_o
);

  always_comb begin
    bad_o = 1'b0;
    if (new_i != cur_i) begin
      if (new_i == MODE_BAD) begin
        bad_o = 1'b1;
      end else if ((cur_i == MODE_EXT) && (new_i != MODE_OFF)) begin
        bad_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lic_base_store.sv
module lic_base_store
  import lic_pkg::*;
#(
  parameter int          DATA_W     = 64,
  parameter int          PA_W       = 36,
  parameter logic [63:0] RESET_BASE = 64'h0000_0000_FEE0_0000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   boot_i,
  input  logic                   wr_en_i,
  input  logic [PA_W-1:BASE_LSB] base_i,
  input  lic_mode_e              mode_i,
  input  logic                   boot_wr_i,
  input  lic_viol_t              viol_i,
  input  logic                   rd_en_i,
  output lic_mode_e              cur_mode_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [PA_W-1:0]        base_addr_o,
  output logic                   fault_o,
  output logic                   reloc_o
);

  logic [PA_W-1:BASE_LSB] base_q;
  lic_mode_e              mode_q;
  logic                   boot_q;
  logic [DATA_W-1:0]      cur_word;
  logic                   accept;
  logic                   commit;

  // Bits above PA_W and reserved bits are never stored: a committed word has them clear.
  always_comb begin
    cur_word                      = '0;
    cur_word[PA_W-1:BASE_LSB]     = base_q;
    cur_word[ENA_POS:MODE_LSB]    = mode_q;
    cur_word[BOOT_POS]            = boot_q;
  end

  assign accept = wr_en_i & mode_q[1];
  assign commit = accept & ~(|viol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= RESET_BASE[PA_W-1:BASE_LSB];
      mode_q    <= MODE_LEGACY;
      boot_q    <= boot_i;
      fault_o   <= 1'b0;
      reloc_o   <= 1'b0;
      rd_data_o <= '0;
    end else begin
      fault_o <= accept & (|viol_i);
      reloc_o <= commit;
      if (commit) begin
        base_q <= base_i;
        mode_q <= mode_i;
        boot_q <= boot_wr_i;
      end
      if (rd_en_i) begin
        rd_data_o <= cur_word;
      end
    end
  end

  assign cur_mode_o  = mode_q;
  assign base_addr_o = {base_q, {BASE_LSB{1'b0}}};

endmodule

// File: rtl/lic_base_reg.sv
module lic_base_reg
  import lic_pkg::*;
#(
  parameter int          DATA_W     = 64,
  parameter int          PA_W       = 36,
  parameter bit          EXT_MODE   = 1'b1,
  parameter logic [63:0] RESET_BASE = 64'h0000_0000_FEE0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PA_W-1:0]   base_addr_o,
  output logic [1:0]        mode_o,
  output logic              fault_o,
  output logic              reloc_o
);

  logic [PA_W-1:BASE_LSB] wr_base;
  lic_mode_e              wr_mode;
  lic_mode_e              cur_mode;
  logic                   wr_boot;
  lic_viol_t              viol;

  lic_field_check #(
    .DATA_W  (DATA_W),
    .PA_W    (PA_W),
    .EXT_MODE(EXT_MODE)
  ) u_field (
    .word_i(wr_data_i),
    .base_o(wr_base),
    .mode_o(wr_mode),
    .boot_o(wr_boot),
    .rsvd_o(viol.rsvd),
    .wide_o(viol.wide)
  );

  lic_mode_check u_mode (
    .cur_i(cur_mode),
    .new_i(wr_mode),
    .bad_o(viol.trans)
  );

  lic_base_store #(
    .DATA_W    (DATA_W),
    .PA_W      (PA_W),
    .RESET_BASE(RESET_BASE)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .boot_i     (boot_i),
    .wr_en_i    (wr_en_i),
    .base_i     (wr_base),
    .mode_i     (wr_mode),
    .boot_wr_i  (wr_boot),
    .viol_i     (viol),
    .rd_en_i    (rd_en_i),
    .cur_mode_o (cur_mode),
    .rd_data_o  (rd_data_o),
    .base_addr_o(base_addr_o),
    .fault_o    (fault_o),
    .reloc_o    (reloc_o)
  );

  assign mode_o = cur_mode;

endmodule

// File: rtl/lic_base_reg_chk.sv
module lic_base_reg_chk #(
  parameter int PA_W     = 36,
  parameter int HI_W     = 28,
  parameter bit EXT_MODE = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en_i,
  input logic [HI_W-1:0] wr_hi_i,
  input logic [8:0]      wr_rsvd_i,
  input logic [PA_W-1:0] base_addr_o,
  input logic [1:0]      mode_o,
  input logic            fault_o,
  input logic            reloc_o
);

  p_pulse_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && reloc_o));

  p_fault_single_r11: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !$past(wr_en_i)) |-> 1'b0);

  p_reloc_cause_r2: assert property (@(posedge clk) disable iff (rst)
    reloc_o |-> $past(wr_en_i));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> ($stable(base_addr_o) && $stable(mode_o)));

  p_rsvd_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && mode_o[1] && (|wr_rsvd_i)) |=> fault_o);

  p_wide_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && mode_o[1] && (|wr_hi_i)) |=> fault_o);

  p_no_bad_mode_r5: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'b01);

  p_ext_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b11) |=> (mode_o == 2'b11 || mode_o == 2'b00));

  p_off_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !mode_o[1]) |=> (!fault_o && !reloc_o));

  generate
    if (!EXT_MODE) begin : g_noext
      p_no_ext_r9: assert property (@(posedge clk) disable iff (rst)
        !mode_o[0]);
    end
  endgenerate

endmodule

bind lic_base_reg lic_base_reg_chk #(
  .PA_W    (PA_W),
  .HI_W    (DATA_W - PA_W),
  .EXT_MODE(EXT_MODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en_i    (wr_en_i),
  .wr_hi_i    (wr_data_i[DATA_W-1:PA_W]),
  .wr_rsvd_i  ({wr_data_i[9], wr_data_i[7:0]}),
  .base_addr_o(base_addr_o),
  .mode_o     (mode_o),
  .fault_o    (fault_o),
  .reloc_o    (reloc_o)
);

// File: tb/test_lic_base_reg.sv
`timescale 1ns/1ps
module test_lic_base_reg;

  localparam int DW  = 64;
  localparam int PAW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boot = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0;

  logic [DW-1:0]  d_rd   [2];
  logic [PAW-1:0] d_base [2];
  logic [1:0]     d_mode [2];
  logic           d_flt  [2];
  logic           d_rel  [2];

  logic [DW-1:0] m_reg [2];
  logic [DW-1:0] m_rd  [2];
  logic          m_flt [2];
  logic          m_rel [2];

  int total = 0;
  int bad = 0;
  bit started = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  lic_base_reg #(.DATA_W(DW), .PA_W(PAW), .EXT_MODE(1'b1)) i_lic_base_reg (
    .clk(clk), .rst(rst), .boot_i(boot), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(d_rd[0]), .base_addr_o(d_base[0]),
    .mode_o(d_mode[0]), .fault_o(d_flt[0]), .reloc_o(d_rel[0]));

  lic_base_reg #(.DATA_W(DW), .PA_W(PAW), .EXT_MODE(1'b0)) i_lic_base_reg_noext (
    .clk(clk), .rst(rst), .boot_i(boot), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(d_rd[1]), .base_addr_o(d_base[1]),
    .mode_o(d_mode[1]), .fault_o(d_flt[1]), .reloc_o(d_rel[1]));

  // Legality of a write from the requirements (R3 R4 R5 R6 R7 R9).
  function automatic bit legal(input logic [DW-1:0] cur, input logic [DW-1:0] d, input bit ext);
    if (d[DW-1:PAW] != '0) return 1'b0;
    if (d[7:0] != 8'h00 || d[9]) return 1'b0;
    if (!ext && d[10]) return 1'b0;
    if (d[11:10] != cur[11:10]) begin
      if (d[11:10] == 2'b01) return 1'b0;
      if (cur[11:10] == 2'b11 && d[11:10] != 2'b00) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Behavioural reference, updated on every clock.
  always @(posedge clk) begin
    started <= 1'b1;
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_reg[i] <= 64'hFEE0_0800 | (64'(boot) << 8);
        m_flt[i] <= 1'b0;
        m_rel[i] <= 1'b0;
        m_rd[i]  <= '0;
      end else begin
        m_flt[i] <= 1'b0;
        m_rel[i] <= 1'b0;
        if (rd_en) m_rd[i] <= m_reg[i];
        if (wr_en && m_reg[i][11]) begin
          if (legal(m_reg[i], wr_data, (i == 0))) begin
            m_reg[i] <= wr_data;
            m_rel[i] <= 1'b1;
          end else begin
            m_flt[i] <= 1'b1;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s t=%0t actual=%h expected=%h", cur_req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int i = 0; i < 2; i++) begin
        check(d_rd[i] === m_rd[i], $sformatf("rd_data[%0d] (R10)", i), d_rd[i], m_rd[i]);
        check(d_base[i] === (m_reg[i][PAW-1:0] & ~36'hFFF), $sformatf("base[%0d] (R2)", i),
              64'(d_base[i]), 64'(m_reg[i][PAW-1:0] & ~36'hFFF));
        check(d_mode[i] === m_reg[i][11:10], $sformatf("mode[%0d] (R2)", i),
              64'(d_mode[i]), 64'(m_reg[i][11:10]));
        check(d_flt[i] === m_flt[i], $sformatf("fault[%0d]", i), 64'(d_flt[i]), 64'(m_flt[i]));
        check(d_rel[i] === m_rel[i], $sformatf("reloc[%0d]", i), 64'(d_rel[i]), 64'(m_rel[i]));
        check(!(d_flt[i] && d_rel[i]), $sformatf("pulse overlap[%0d] (R11)", i),
              64'({d_flt[i], d_rel[i]}), 64'(0));
      end
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [DW-1:0] d, input string req);
    @(posedge clk); #2;
    cur_req = req;
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
    idle(1);
  endtask

  task automatic rd(input string req);
    @(posedge clk); #2;
    cur_req = req;
    rd_en = 1'b1;
    @(posedge clk); #2;
    rd_en = 1'b0;
    idle(1);
  endtask

  task automatic do_reset(input logic b);
    @(posedge clk); #2;
    cur_req = "R1";
    boot = b;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired t=%0t actual=hung expected=finished", $time);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    rd("R1");
    wr(64'h0000_0000_FEC0_0900, "R2");
    rd("R10");
    wr(64'h0000_0000_FEE0_0808, "R3");
    wr(64'h0000_0000_FEE0_0A00, "R3");
    wr(64'h0000_0010_FEE0_0800, "R4");
    wr(64'h8000_0000_FEE0_0800, "R4");
    wr(64'h0000_0000_FEE0_0400, "R5");
    wr(64'h0000_0000_FEE0_0C00, "R9");
    wr(64'h0000_0000_ABC0_0C00, "R7");
    rd("R10");
    wr(64'h0000_0000_ABC0_0800, "R6");
    wr(64'h0000_0000_ABC0_0400, "R5");
    wr(64'h0000_0000_1234_5000, "R6");
    wr(64'h0000_00FF_1234_5FFF, "R8");
    wr(64'h0000_0000_2000_0800, "R8");
    rd("R8");
    do_reset(1'b0);
    rd("R1");
    for (int n = 0; n < 600; n++) begin
      logic [DW-1:0] d;
      d = '0;
      d[PAW-1:12] = 24'($urandom);
      d[11:10] = 2'($urandom);
      d[8] = 1'($urandom);
      if ($urandom_range(0, 7) == 0) d[$urandom_range(0, 9)] = 1'b1;
      if ($urandom_range(0, 9) == 0) d[$urandom_range(PAW, DW - 1)] = 1'b1;
      if ($urandom_range(0, 3) == 0) rd("R10");
      else wr(d, "R11");
      if (!m_reg[0][11] && $urandom_range(0, 5) == 0) do_reset(1'($urandom));
    end
    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule